// File: doc/BRIEF.md
# Early Branch Target Check and Redirect

This block sits in the decode stage of an out-of-order core. Each cycle it receives a group of up to `W` instruction records in program order. It inspects the direct, unconditional control transfers in that group. For each such instruction it compares the target computed at decode with the target that fetch predicted. The first instruction in the group whose two targets disagree produces a redirect for fetch. That redirect carries the computed target as the new fetch address, names the offending instruction by sequence number as the last good one, and reports whether the instruction actually leaves the sequential path.

The block also reports which slots of the group go on to rename and which slots must be squashed. Slots up to and including the offending one are forwarded. The group is cut off after that slot. A later slot is squashed only when it belongs to the same thread and is younger than the offender. A predicted-taken flag on a non-control instruction raises a fatal indication. Two running counters track how many transfers were checked and how many redirects were issued.

All results are registered and appear one clock after the group is presented.

Top module: `early_redirect`

## Requirements
- R1: Only a valid slot whose direct and unconditional flags are both 1 is checked. A conditional or indirect slot, or an invalid slot, never causes a redirect, whatever its targets are.
- R2: The first checked slot (lowest index) whose computed target differs from its predicted target sets `redir_valid` to 1 one cycle later. In that cycle `redir_seq` and `redir_tid` hold that slot's sequence number and thread, and `redir_pc` holds its computed target. A later mismatch in the same group is ignored.
- R3: `pass_mask` bit i is 1 when slot i is valid and no valid mismatching slot has a lower index. The offending slot is itself passed, and no slot after it is passed.
- R4: `kill_mask` bit i is 1 when slot i lies after the offending slot, is valid, has the same thread, and has a sequence number greater than the offender's, compared as unsigned. Without a redirect `kill_mask` is 0.
- R5: `redir_taken` is 1 when the offending slot's next PC differs from its PC plus `INSN_BYTES`, which defaults to 4.
- R6: `fatal` is 1 one cycle after a group that contains a passed slot with predicted-taken 1 and control 0. A slot that is cut off by an earlier mismatch does not raise it.
- R7: `resolved_cnt` grows by the number of passed slots that are checked, modulo 2^CW.
- R8: `mispred_cnt` grows by exactly 1 for each group that produces a redirect, and holds its value otherwise.
- R9: During reset and right after it, every output is 0.
- R10: Each result reflects only the group from the previous cycle. A cycle with no valid slots yields `redir_valid`, `pass_mask`, `kill_mask` and `fatal` all 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | W | Slot holds an instruction |
| grp_tid | input | W x TW | Thread of each slot |
| grp_seq | input | W x SW | Sequence number of each slot |
| grp_pc | input | W x AW | PC of each slot |
| grp_next_pc | input | W x AW | Next PC of each slot |
| grp_calc_tgt | input | W x AW | Target computed at decode |
| grp_pred_tgt | input | W x AW | Target predicted by fetch |
| grp_pred_taken | input | W | Fetch predicted taken |
| grp_is_ctrl | input | W | Slot is a control transfer |
| grp_is_direct | input | W | Target is PC-relative |
| grp_is_uncond | input | W | Transfer is unconditional |
| redir_valid | output | 1 | Redirect issued (mispredict, prediction wrong, squash) |
| redir_tid | output | TW | Thread of the redirect |
| redir_seq | output | SW | Last good sequence number |
| redir_pc | output | AW | New fetch PC (corrected target) |
| redir_taken | output | 1 | Offender leaves the sequential path |
| pass_mask | output | W | Slots forwarded to rename |
| kill_mask | output | W | Slots marked squashed |
| fatal | output | 1 | Predicted-taken non-control seen |
| resolved_cnt | output | CW | Checked transfers so far |
| mispred_cnt | output | CW | Redirects issued so far |

## Verification
Every output of this block is due exactly one rising edge after its group is driven, because it sits behind a single register stage. The bench drives each group on a falling edge and lets one rising edge pass. It samples every output at the next falling edge, then withdraws the group in that same half cycle. As a result each group is counted once, and any state left over shows up in the next scenario's idle check. The counter expectations advance inside the bench by the amounts the requirements give for each group.

// File: rtl/er_pkg.sv
package er_pkg;

    typedef struct packed {
        logic checked;   // direct and unconditional
        logic mismatch;  // checked and targets differ
        logic bad_pred;  // predicted taken on a non-control
    } slot_verdict_t;

endpackage

// File: rtl/er_slot_check.sv
module er_slot_check
    import er_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          is_ctrl,
    input  logic          is_direct,
    input  logic          is_uncond,
    input  logic          pred_taken,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] calc_tgt,
    input  logic [AW-1:0] pred_tgt,
    output slot_verdict_t verdict,
    output logic          leaves_seq
);

    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    always_comb begin
        verdict.checked  = is_direct & is_uncond;
        verdict.mismatch = verdict.checked & (calc_tgt != pred_tgt);
        verdict.bad_pred = pred_taken & ~is_ctrl;
        leaves_seq       = (next_pc != (pc + STEP));
    end

endmodule

// File: rtl/er_first_hit.sv
module er_first_hit #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  hit,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  clear_before
);

    logic [W:0] none_yet;
    assign none_yet[0] = 1'b1;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign none_yet[g+1]   = none_yet[g] & ~hit[g];
        assign clear_before[g] = none_yet[g];
    end

    assign found = ~none_yet[W];

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (hit[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/early_redirect.sv
module early_redirect
    import er_pkg::*;
#(
    parameter int W          = 4,
    parameter int AW         = 32,
    parameter int SW         = 32,
    parameter int TW         = 2,
    parameter int CW         = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           grp_valid,
    input  logic [W-1:0][TW-1:0]   grp_tid,
    input  logic [W-1:0][SW-1:0]   grp_seq,
    input  logic [W-1:0][AW-1:0]   grp_pc,
    input  logic [W-1:0][AW-1:0]   grp_next_pc,
    input  logic [W-1:0][AW-1:0]   grp_calc_tgt,
    input  logic [W-1:0][AW-1:0]   grp_pred_tgt,
    input  logic [W-1:0]           grp_pred_taken,
    input  logic [W-1:0]           grp_is_ctrl,
    input  logic [W-1:0]           grp_is_direct,
    input  logic [W-1:0]           grp_is_uncond,
    output logic                   redir_valid,
    output logic [TW-1:0]          redir_tid,
    output logic [SW-1:0]          redir_seq,
    output logic [AW-1:0]          redir_pc,
    output logic                   redir_taken,
    output logic [W-1:0]           pass_mask,
    output logic [W-1:0]           kill_mask,
    output logic                   fatal,
    output logic [CW-1:0]          resolved_cnt,
    output logic [CW-1:0]          mispred_cnt
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          redir_valid;
        logic [TW-1:0] redir_tid;
        logic [SW-1:0] redir_seq;
        logic [AW-1:0] redir_pc;
        logic          redir_taken;
        logic [W-1:0]  pass_mask;
        logic [W-1:0]  kill_mask;
        logic          fatal;
        logic [CW-1:0] resolved_cnt;
        logic [CW-1:0] mispred_cnt;
    } state_t;

    slot_verdict_t [W-1:0] verdict;
    logic [W-1:0]          leaves_seq;
    logic [W-1:0]          hit;
    logic [W-1:0]          clear_before;
    logic                  found;
    logic [IW-1:0]         hit_idx;

    for (genvar g = 0; g < W; g++) begin : g_slot
        er_slot_check #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_chk (
            .is_ctrl    (grp_is_ctrl[g]),
            .is_direct  (grp_is_direct[g]),
            .is_uncond  (grp_is_uncond[g]),
            .pred_taken (grp_pred_taken[g]),
            .pc         (grp_pc[g]),
            .next_pc    (grp_next_pc[g]),
            .calc_tgt   (grp_calc_tgt[g]),
            .pred_tgt   (grp_pred_tgt[g]),
            .verdict    (verdict[g]),
            .leaves_seq (leaves_seq[g])
        );
        assign hit[g] = grp_valid[g] & verdict[g].mismatch;
    end

    er_first_hit #(.W(W)) u_first (
        .hit          (hit),
        .found        (found),
        .idx          (hit_idx),
        .clear_before (clear_before)
    );

    state_t st_q, st_d;

    always_comb begin
        logic [W-1:0]  passed;
        logic [CW-1:0] checked_n;
        st_d      = st_q;
        passed    = grp_valid & clear_before;
        checked_n = '0;
        st_d.fatal = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (passed[i] && verdict[i].checked) checked_n = checked_n + CW'(1);
            if (passed[i] && verdict[i].bad_pred) st_d.fatal = 1'b1;
        end
        st_d.pass_mask    = passed;
        st_d.redir_valid  = found;
        st_d.redir_tid    = found ? grp_tid[hit_idx]      : '0;
        st_d.redir_seq    = found ? grp_seq[hit_idx]      : '0;
        st_d.redir_pc     = found ? grp_calc_tgt[hit_idx] : '0;
        st_d.redir_taken  = found & leaves_seq[hit_idx];
        st_d.kill_mask    = '0;
        for (int i = 0; i < W; i++) begin
            if (found && (IW'(i) > hit_idx) && grp_valid[i] &&
                (grp_tid[i] == grp_tid[hit_idx]) &&
                (grp_seq[i] > grp_seq[hit_idx]))
                st_d.kill_mask[i] = 1'b1;
        end
        st_d.resolved_cnt = st_q.resolved_cnt + checked_n;
        st_d.mispred_cnt  = st_q.mispred_cnt + (found ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redir_valid  = st_q.redir_valid;
    assign redir_tid    = st_q.redir_tid;
    assign redir_seq    = st_q.redir_seq;
    assign redir_pc     = st_q.redir_pc;
    assign redir_taken  = st_q.redir_taken;
    assign pass_mask    = st_q.pass_mask;
    assign kill_mask    = st_q.kill_mask;
    assign fatal        = st_q.fatal;
    assign resolved_cnt = st_q.resolved_cnt;
    assign mispred_cnt  = st_q.mispred_cnt;

endmodule

// File: rtl/er_checker.sv
module er_checker #(
    parameter int W  = 4,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          redir_valid,
    input logic [W-1:0]  pass_mask,
    input logic [W-1:0]  kill_mask,
    input logic [CW-1:0] resolved_cnt,
    input logic [CW-1:0] mispred_cnt
);

    p_kill_needs_redir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_mask != '0) |-> redir_valid);

    p_pass_kill_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_mask & kill_mask) == '0);

    p_redir_has_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (pass_mask != '0));

    p_mispred_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (mispred_cnt == $past(mispred_cnt) + CW'(1)));

    p_mispred_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> $stable(mispred_cnt));

    p_resolved_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (resolved_cnt != $past(resolved_cnt)));

endmodule

bind early_redirect er_checker #(.W(W), .CW(CW)) u_er_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .redir_valid  (redir_valid),
    .pass_mask    (pass_mask),
    .kill_mask    (kill_mask),
    .resolved_cnt (resolved_cnt),
    .mispred_cnt  (mispred_cnt)
);

// File: tb/sim_early_redirect.sv
`timescale 1ns/1ps
module sim_early_redirect;

    localparam int W = 4, AW = 32, SW = 32, TW = 2, CW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [W-1:0]         g_valid;
    logic [W-1:0][TW-1:0] g_tid;
    logic [W-1:0][SW-1:0] g_seq;
    logic [W-1:0][AW-1:0] g_pc, g_next, g_calc, g_pred;
    logic [W-1:0]         g_pt, g_ctl, g_dir, g_unc;

    logic                 redir_valid, redir_taken, fatal;
    logic [TW-1:0]        redir_tid;
    logic [SW-1:0]        redir_seq;
    logic [AW-1:0]        redir_pc;
    logic [W-1:0]         pass_mask, kill_mask;
    logic [CW-1:0]        resolved_cnt, mispred_cnt;

    int n_checks = 0, n_fail = 0;
    int exp_res = 0, exp_mis = 0;

    always #10 clk = ~clk;

    early_redirect u0 (
        .clk(clk), .rst_n(rst_n),
        .grp_valid(g_valid), .grp_tid(g_tid), .grp_seq(g_seq), .grp_pc(g_pc),
        .grp_next_pc(g_next), .grp_calc_tgt(g_calc), .grp_pred_tgt(g_pred),
        .grp_pred_taken(g_pt), .grp_is_ctrl(g_ctl), .grp_is_direct(g_dir),
        .grp_is_uncond(g_unc),
        .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_seq(redir_seq),
        .redir_pc(redir_pc), .redir_taken(redir_taken), .pass_mask(pass_mask),
        .kill_mask(kill_mask), .fatal(fatal), .resolved_cnt(resolved_cnt),
        .mispred_cnt(mispred_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_group();
        g_valid = '0; g_tid = '0; g_seq = '0; g_pc = '0; g_next = '0;
        g_calc = '0; g_pred = '0; g_pt = '0; g_ctl = '0; g_dir = '0; g_unc = '0;
    endtask

    // plain sequential instruction
    task automatic plain(input int i, input int tid, input int seq, input int pc);
        g_valid[i] = 1'b1; g_tid[i] = TW'(tid); g_seq[i] = SW'(seq);
        g_pc[i] = AW'(pc); g_next[i] = AW'(pc + 4);
        g_calc[i] = '0; g_pred[i] = '0;
        g_pt[i] = 1'b0; g_ctl[i] = 1'b0; g_dir[i] = 1'b0; g_unc[i] = 1'b0;
    endtask

    // control transfer in slot i
    task automatic xfer(input int i, input int tid, input int seq, input int pc,
                        input logic dir, input logic unc, input int calc,
                        input int pred, input int nxt);
        plain(i, tid, seq, pc);
        g_ctl[i] = 1'b1; g_pt[i] = 1'b1; g_dir[i] = dir; g_unc[i] = unc;
        g_calc[i] = AW'(calc); g_pred[i] = AW'(pred); g_next[i] = AW'(nxt);
    endtask

    // drive for one rising edge, sample at the next falling edge, withdraw
    task automatic run_group();
        @(posedge clk);
        @(negedge clk);
        clear_group();
    endtask

    task automatic chk_counts(input string req);
        chk({req, " resolved_cnt"}, 64'(resolved_cnt), 64'(exp_res));
        chk({req, " mispred_cnt"}, 64'(mispred_cnt), 64'(exp_mis));
    endtask

    task automatic t_reset();
        chk("R9 redir_valid", 64'(redir_valid), 0);
        chk("R9 pass_mask", 64'(pass_mask), 0);
        chk("R9 kill_mask", 64'(kill_mask), 0);
        chk("R9 fatal", 64'(fatal), 0);
        chk_counts("R9");
    endtask

    task automatic t_plain();
        for (int i = 0; i < W; i++) plain(i, 0, 10 + i, 'h100 + 4 * i);
        run_group();
        chk("R1 plain redir", 64'(redir_valid), 0);
        chk("R3 plain pass", 64'(pass_mask), 64'hf);
        chk_counts("R7 plain");
    endtask

    task automatic t_match();
        for (int i = 0; i < W; i++) plain(i, 0, 10 + i, 'h100 + 4 * i);
        xfer(2, 0, 12, 'h108, 1, 1, 'h400, 'h400, 'h400);
        run_group();
        exp_res += 1;
        chk("R1 match redir", 64'(redir_valid), 0);
        chk("R3 match pass", 64'(pass_mask), 64'hf);
        chk_counts("R7 match");
    endtask

    task automatic t_cond();
        for (int i = 0; i < W; i++) plain(i, 0, 10 + i, 'h100 + 4 * i);
        xfer(1, 0, 11, 'h104, 1, 0, 'h200, 'h300, 'h200);
        xfer(2, 0, 12, 'h108, 0, 1, 'h200, 'h300, 'h200);
        run_group();
        chk("R1 cond/indirect redir", 64'(redir_valid), 0);
        chk("R1 cond/indirect kill", 64'(kill_mask), 0);
        chk_counts("R1 cond");
    endtask

    task automatic t_mismatch();
        for (int i = 0; i < W; i++) plain(i, 0, 10 + i, 'h100 + 4 * i);
        xfer(1, 0, 11, 'h104, 1, 1, 'h200, 'h300, 'h200);
        run_group();
        exp_res += 1; exp_mis += 1;
        chk("R2 redir_valid", 64'(redir_valid), 1);
        chk("R2 redir_seq", 64'(redir_seq), 11);
        chk("R2 redir_pc", 64'(redir_pc), 'h200);
        chk("R2 redir_tid", 64'(redir_tid), 0);
        chk("R5 taken", 64'(redir_taken), 1);
        chk("R3 pass", 64'(pass_mask), 64'h3);
        chk("R4 kill", 64'(kill_mask), 64'hc);
        chk_counts("R8 mismatch");
    endtask

    task automatic t_idle();
        run_group();
        chk("R10 idle redir", 64'(redir_valid), 0);
        chk("R10 idle pass", 64'(pass_mask), 0);
        chk("R10 idle kill", 64'(kill_mask), 0);
        chk_counts("R8 idle");
    endtask

    task automatic t_threads();
        xfer(0, 1, 20, 'h500, 1, 1, 'h600, 'h640, 'h600);
        plain(1, 1, 21, 'h504);
        plain(2, 0, 22, 'h900);
        plain(3, 1, 5, 'h508);
        run_group();
        exp_res += 1; exp_mis += 1;
        chk("R2 thread tid", 64'(redir_tid), 1);
        chk("R3 thread pass", 64'(pass_mask), 64'h1);
        chk("R4 thread kill", 64'(kill_mask), 64'h2);
        chk_counts("R8 thread");
    endtask

    task automatic t_not_taken();
        for (int i = 0; i < W; i++) plain(i, 2, 30 + i, 'h700 + 4 * i);
        xfer(3, 2, 33, 'h70c, 1, 1, 'h800, 'h880, 'h710);
        run_group();
        exp_res += 1; exp_mis += 1;
        chk("R5 not taken", 64'(redir_taken), 0);
        chk("R2 last slot seq", 64'(redir_seq), 33);
        chk("R3 last slot pass", 64'(pass_mask), 64'hf);
        chk("R4 last slot kill", 64'(kill_mask), 0);
        chk_counts("R8 last slot");
    endtask

    task automatic t_two();
        plain(0, 0, 40, 'h100);
        xfer(1, 0, 41, 'h104, 1, 1, 'h200, 'h204, 'h200);
        xfer(2, 0, 42, 'h108, 1, 1, 'h300, 'h304, 'h300);
        plain(3, 0, 43, 'h10c);
        run_group();
        exp_res += 1; exp_mis += 1;
        chk("R2 first wins seq", 64'(redir_seq), 41);
        chk("R2 first wins pc", 64'(redir_pc), 'h200);
        chk("R4 two kill", 64'(kill_mask), 64'hc);
        chk_counts("R7 two");
    endtask

    task automatic t_invalid();
        xfer(0, 0, 50, 'h100, 1, 1, 'h200, 'h300, 'h200);
        g_valid[0] = 1'b0;
        plain(1, 0, 51, 'h104);
        plain(2, 0, 52, 'h108);
        plain(3, 0, 53, 'h10c);
        run_group();
        chk("R1 invalid redir", 64'(redir_valid), 0);
        chk("R3 invalid pass", 64'(pass_mask), 64'he);
        chk_counts("R7 invalid");
    endtask

    task automatic t_fatal();
        for (int i = 0; i < W; i++) plain(i, 0, 60 + i, 'h100 + 4 * i);
        g_pt[2] = 1'b1;
        run_group();
        chk("R6 fatal raised", 64'(fatal), 1);
        xfer(0, 0, 70, 'h100, 1, 1, 'h200, 'h300, 'h200);
        plain(1, 0, 71, 'h104);
        g_pt[1] = 1'b1;
        run_group();
        exp_res += 1; exp_mis += 1;
        chk("R6 fatal cut off", 64'(fatal), 0);
        chk("R4 fatal kill", 64'(kill_mask), 64'h2);
        run_group();
        chk("R10 fatal clears", 64'(fatal), 0);
        chk_counts("R8 fatal");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        clear_group();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_match();
        t_cond();
        t_mismatch();
        t_idle();
        t_threads();
        t_not_taken();
        t_two();
        t_invalid();
        t_fatal();
        t_idle();
        finish_run();
    end

endmodule